// File: doc/BRIEF.md
# Overwriting Command History Silo

This block keeps a running record of the command codes that arrive on a live command stream. Each accepted command code is appended to a circular history store that is `DEPTH` entries deep and `CODE_W` bits wide. When the store is already full, the new code takes the place of the oldest one. This means the store always holds the most recent `DEPTH` commands, and the command stream is never stalled.

A host drains the history oldest-first through a show-ahead read port. Recording can be frozen in two ways. The first is a host-written control bit. The second is the arrival of a designated "latch status" command code. A freeze caused by that code is sticky, so the captured sequence is preserved for inspection until the host writes the control bit again or the block is reset. Bus decoding and command execution sit outside this block.

Top module: `cmd_history_silo`

## Requirements
- R1: After reset, `hist_empty` is 1, `hist_count` is 0 and recording is enabled.
- R2: Each cycle with `cmd_valid` high while recording is enabled appends `cmd_code` at the tail, and `hist_count` rises by one until it reaches `DEPTH`.
- R3: An append while `hist_count` equals `DEPTH` discards the oldest entry, and `hist_count` stays at `DEPTH`.
- R4: `hist_data` always shows the oldest stored entry. A cycle with `rd_en` high and `hist_empty` low removes that entry and lowers `hist_count` by one, so codes leave in arrival order.
- R5: `rd_en` while `hist_empty` is 1 has no effect: the count stays 0 and later data is unaffected.
- R6: An append and a read in the same cycle leave `hist_count` unchanged.
- R7: A cycle with `ctl_wr` high loads `ctl_freeze` into the host freeze bit. While that bit is 1, `cmd_valid` appends nothing.
- R8: An accepted command whose code equals `LATCH_CODE` is itself stored, and then freezes recording from the next cycle on.
- R9: The freeze set by `LATCH_CODE` persists until a `ctl_wr` cycle clears it. If a `ctl_wr` and an accepted `LATCH_CODE` fall in the same cycle, the freeze set by the code wins.
- R10: Reads keep working while recording is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command code is present this cycle |
| cmd_code | input | CODE_W | Command code to record |
| ctl_wr | input | 1 | Host write strobe for the freeze control bit |
| ctl_freeze | input | 1 | Value written to the host freeze bit |
| rd_en | input | 1 | Host pop of the oldest entry |
| hist_data | output | CODE_W | Oldest stored code (show-ahead) |
| hist_empty | output | 1 | No entries stored |
| hist_count | output | $clog2(DEPTH)+1 | Number of stored entries |

## Verification
The bench builds the block with `DEPTH` set to 16 and a non-default `LATCH_CODE`. A depth of 16 makes pointer wrap-around, many full-store overwrites, and repeated fill-and-drain cycles reachable in a few thousand cycles. The pointer and count logic is the same as at the default depth of 2048, because only the index width changes. Directed phases cover each requirement, including an empty-store pop and a clear of the latch freeze in the same cycle as a new latch code. A long random mix follows, with the latch code injected at intervals.

// File: rtl/cmd_silo_pkg.sv
package cmd_silo_pkg;
    typedef struct packed {
        logic host_frz;
        logic latch_frz;
    } frz_state_t;
endpackage

// File: rtl/cmd_silo_freeze.sv
module cmd_silo_freeze
    import cmd_silo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_freeze,
    input  logic latch_hit,
    output logic frozen
);
    frz_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.host_frz  = ctl_freeze;
            st_d.latch_frz = 1'b0;
        end
        if (latch_hit) begin
            st_d.latch_frz = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frozen = st_q.host_frz | st_q.latch_frz;

    // R9: a latch freeze holds until a host write
    a_r9_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch_frz && !ctl_wr) |=> st_q.latch_frz);
    // R8: an accepted latch code freezes the next cycle
    a_r8_latch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        latch_hit |=> frozen);
endmodule

// File: rtl/cmd_silo_ctrl.sv
module cmd_silo_ctrl #(
    parameter int DEPTH = 2048
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       rd_req,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_state_t;

    ptr_state_t s_d, s_q;
    logic full, pop;

    assign full = (s_q.cnt == FULL_CNT);
    assign pop  = rd_req && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = s_q.wr + 1'b1;
        if (pop || (push && full)) s_d.rd = s_q.rd + 1'b1;
        if (push && !pop && !full) s_d.cnt = s_q.cnt + 1'b1;
        else if (pop && !push)     s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_ptr = s_q.wr;
    assign rd_ptr = s_q.rd;
    assign count  = s_q.cnt;
    assign empty  = (s_q.cnt == '0);

    // R2: the count never exceeds the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R3: an overwrite keeps the store full
    a_r3_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> (count == FULL_CNT));
    // R5: a pop of an empty store does nothing
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !push) |=> (count == '0));
    // R6: a push and a pop together keep the count
    a_r6_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rd_req && !empty) |=> $stable(count));
endmodule

// File: rtl/cmd_silo_mem.sv
module cmd_silo_mem #(
    parameter int DEPTH  = 2048,
    parameter int CODE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [CODE_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [CODE_W-1:0]        rdata
);
    logic [CODE_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/cmd_history_silo.sv
module cmd_history_silo #(
    parameter int          DEPTH      = 2048,
    parameter int          CODE_W     = 9,
    parameter logic [8:0]  LATCH_CODE = 9'h0F0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [CODE_W-1:0]        cmd_code,
    input  logic                     ctl_wr,
    input  logic                     ctl_freeze,
    input  logic                     rd_en,
    output logic [CODE_W-1:0]        hist_data,
    output logic                     hist_empty,
    output logic [$clog2(DEPTH):0]   hist_count
);
    localparam int AW = $clog2(DEPTH);

    logic          frozen, accept, latch_hit;
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign accept    = cmd_valid && !frozen;
    assign latch_hit = accept && (cmd_code == CODE_W'(LATCH_CODE));

    cmd_silo_freeze u_frz (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_freeze(ctl_freeze),
        .latch_hit(latch_hit), .frozen(frozen)
    );

    cmd_silo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(accept), .rd_req(rd_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(hist_count), .empty(hist_empty)
    );

    cmd_silo_mem #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_mem (
        .clk(clk), .we(accept), .waddr(wr_ptr), .wdata(cmd_code),
        .raddr(rd_ptr), .rdata(hist_data)
    );

    // R7: while frozen, only reads may move the count
    a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !rd_en) |=> $stable(hist_count));
    // R4: a pop of a non-empty store lowers the count
    a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hist_empty && !accept) |=> (hist_count == $past(hist_count) - 1'b1));
endmodule

// File: tb/sim_cmd_history_silo.sv
module sim_cmd_history_silo;
    localparam int TCLK   = 10;
    localparam int DEPTH  = 16;
    localparam int CODE_W = 9;
    localparam logic [8:0] LATCH = 9'h1A5;
    localparam int CW = $clog2(DEPTH) + 1;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, ctl_wr = 0, ctl_freeze = 0, rd_en = 0;
    logic [CODE_W-1:0] cmd_code = '0;
    logic [CODE_W-1:0] hist_data;
    logic hist_empty;
    logic [CW-1:0] hist_count;

    int vectors = 0, fails = 0;
    string req = "R1";
    logic [CODE_W-1:0] mq[$];
    bit m_host = 0, m_latch = 0;

    always #(TCLK/2) clk = ~clk;

    cmd_history_silo #(.DEPTH(DEPTH), .CODE_W(CODE_W), .LATCH_CODE(LATCH)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .ctl_wr(ctl_wr), .ctl_freeze(ctl_freeze), .rd_en(rd_en),
        .hist_data(hist_data), .hist_empty(hist_empty), .hist_count(hist_count)
    );

    task automatic compare();
        vectors++;
        if (hist_count !== CW'(mq.size())) begin
            fails++;
            $display("FAIL %s count actual=%0d expected=%0d", req, hist_count, mq.size());
        end
        if (hist_empty !== (mq.size() == 0)) begin
            fails++;
            $display("FAIL %s empty actual=%0b expected=%0b", req, hist_empty, mq.size() == 0);
        end
        if (mq.size() != 0 && hist_data !== mq[0]) begin
            fails++;
            $display("FAIL %s data actual=%h expected=%h", req, hist_data, mq[0]);
        end
    endtask

    // apply inputs after the falling edge, update model, wait for next falling edge and compare
    task automatic step(bit v, logic [CODE_W-1:0] c, bit r, bit cw, bit cf);
        bit frz, acc;
        cmd_valid = v; cmd_code = c; rd_en = r; ctl_wr = cw; ctl_freeze = cf;
        frz = m_host | m_latch;
        acc = v && !frz;
        if (r && mq.size() != 0) void'(mq.pop_front());
        if (acc) begin
            mq.push_back(c);
            if (mq.size() > DEPTH) void'(mq.pop_front());
        end
        if (cw) begin m_host = cf; m_latch = 0; end
        if (acc && c == LATCH) m_latch = 1;
        @(negedge clk);
        compare();
    endtask

    function automatic logic [CODE_W-1:0] rcode();
        logic [CODE_W-1:0] c;
        c = CODE_W'($urandom);
        if (c == LATCH) c = c ^ 9'h001;
        return c;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        req = "R1"; compare();
        req = "R5"; step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 0);
        req = "R2"; for (int i = 0; i < DEPTH; i++) step(1, rcode(), 0, 0, 0);
        req = "R3"; for (int i = 0; i < 2*DEPTH+3; i++) step(1, rcode(), 0, 0, 0);
        req = "R6"; for (int i = 0; i < 10; i++) step(1, rcode(), 1, 0, 0);
        req = "R4"; for (int i = 0; i < DEPTH-4; i++) step(0, 0, 1, 0, 0);
        req = "R6"; for (int i = 0; i < 6; i++) step(1, rcode(), 1, 0, 0);
        req = "R4"; for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0);
        req = "R5"; step(0, 0, 1, 0, 0); step(1, 9'h033, 1, 0, 0); step(0, 0, 1, 0, 0);
        req = "R7"; step(0, 0, 0, 1, 1);
        for (int i = 0; i < 5; i++) step(1, rcode(), 0, 0, 0);
        step(1, LATCH, 0, 1, 0);
        for (int i = 0; i < 4; i++) step(1, rcode(), 0, 0, 0);
        req = "R8"; step(1, LATCH, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1, rcode(), 0, 0, 0);
        req = "R10"; for (int i = 0; i < 3; i++) step(1, rcode(), 1, 0, 0);
        req = "R9"; step(1, LATCH, 0, 1, 0);
        step(1, rcode(), 0, 0, 0);
        step(1, LATCH, 0, 0, 0);
        step(1, LATCH, 0, 1, 0);
        step(1, rcode(), 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(1, LATCH, 0, 1, 0);
        step(1, rcode(), 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(1, rcode(), 0, 0, 0);
        req = "mix";
        for (int i = 0; i < 4000; i++) begin
            bit v, r, cw;
            logic [CODE_W-1:0] c;
            v  = ($urandom % 4) != 0;
            r  = ($urandom % 3) == 0;
            cw = ($urandom % 40) == 0;
            c  = (($urandom % 60) == 0) ? LATCH : rcode();
            step(v, c, r, cw, ($urandom % 3) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule